// File: doc/BRIEF.md
# Indexed Register Window for a CD Data Controller

This block is the host-facing register window of a CD data controller. The host reaches all of the controller's byte registers through two ports: a 4-bit register index and an 8-bit data port. Each data-port read or write acts on the register that the index selects. Afterwards the index normally steps to the next register, so the host can stream through a group of registers without rewriting the index. Reads and writes reach different register sets at the same index.

The window holds several registers. The 16-bit byte count, data address, pointer and write address are each split into low and high bytes. It also holds four header bytes, four status bytes, three control bytes, an interface-control byte, an interface-status byte and a sub-bus output byte. Certain accesses act on the interface-status flags and on the transfer state. These include the transfer trigger, the transfer acknowledge, clearing interface-control bit 1, the read of the last status byte, and the soft reset.

The transfer engine and the header generator lie outside this block. The header bytes are loaded from an input bus. Two event inputs let the engine raise the active-low interrupt flags.

Top module: `cdc_regfile`

## Requirements
- R1: The read data is a combinational function of the current index. It follows this map:
  - 0: `cmd_in`
  - 1: interface status
  - 2 and 3: byte count low and high
  - 4–7: header bytes 0–3 (byte k is `hdr` bits 8k+7:8k)
  - 8 and 9: pointer low and high
  - A and B: write address low and high
  - C–F: status bytes 0–3
- R2: A data write stores `wr_data` according to this map:
  - 0: sub-bus out
  - 1: interface control
  - 2 and 3: byte count low and high
  - 4 and 5: data address low and high
  - 8 and 9: write address low and high
  - A: control byte 0 (`ctrl_o[7:0]`)
  - B: control byte 1 (`ctrl_o[15:8]`)
  - C and D: pointer low and high
  - E: control byte 2 (`ctrl_o[23:16]`)
- R3: After a data access at index n, the index becomes n+1, wrapping from F to 0. The exceptions are writes at 6, 7, E and F, and a read at F: these leave the index unchanged.
- R4: Asserting `idx_we` loads `idx_wdata` into the index on that clock edge. A data access in the same cycle acts at the old index, and `idx_we` overrides that access's index step.
- R5: A write at index 1 with bit 1 clear sets the following on the next cycle: the byte count to 0, `busy_o` to 0 and interface-status bit 3 to 1.
- R6: A write at index 6 while interface-control bit 1 is set sets the following on the next cycle: interface-status bit 3 to 0, `busy_o` to 1, and a one-cycle pulse on `xfer_start_o`, which tells the engine to clear its end-of-transfer flag. With bit 1 clear, the write does nothing.
- R7: A write at index 7 sets interface-status bit 6. A `dte_evt` pulse clears bit 6 and a `dec_evt` pulse clears bit 5. An event wins over a host access in the same cycle.
- R8: A read at index F sets interface-status bit 5. If control byte 0 bit 7 and interface-control bit 5 are both set, and registers 1, 4–9, C, D and E have each been read since reset (mask 0x73F2), status byte 3 becomes 0x80.
- R9: Hardware reset sets the following values:
  - interface status 0xFF
  - header 0x01000000 (header byte 3 = 0x01)
  - write address 4704 (0x1260)
  - status 0x00000080 (status byte 0 = 0x80)
  - all other registers, `busy_o` and the read mask to 0
  - index 0

  A write at index F applies the same values to everything except the index, wins over every other update in that cycle, and pulses `soft_rst_o` for one cycle.
- R10: If `rd_en` and `wr_en` are both high, only the write takes effect and the read has no side effect.
- R11: A `hdr_load` pulse loads `hdr_in` into the header on the next edge, unless a soft reset happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| idx_we | input | 1 | Load the register index |
| idx_wdata | input | 4 | New index value |
| rd_en | input | 1 | Data-port read strobe |
| wr_en | input | 1 | Data-port write strobe |
| wr_data | input | 8 | Data-port write value |
| rd_data | output | 8 | Data-port read value at the current index |
| cmd_in | input | 8 | Command-in byte seen at read index 0 |
| hdr_load | input | 1 | Load the header bytes |
| hdr_in | input | 32 | Header bytes, byte 0 in bits 7:0 |
| dte_evt | input | 1 | Engine raises the end-of-transfer interrupt |
| dec_evt | input | 1 | Engine raises the decode interrupt |
| idx_o | output | 4 | Current register index |
| busy_o | output | 1 | Transfer in progress |
| xfer_start_o | output | 1 | One-cycle transfer start pulse |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |
| ifstat_o | output | 8 | Interface status byte |
| ifctrl_o | output | 8 | Interface control byte |
| ctrl_o | output | 24 | Control bytes 2, 1, 0 |
| sbout_o | output | 8 | Sub-bus output byte |
| byte_cnt_o | output | 16 | Byte count |
| data_addr_o | output | 16 | Data address |

## Verification
The hardest state to reach is the decode-complete case of status byte 3. It needs two enable bits set by writes, plus ten separate reads that are scattered across the index space. None of these is visible until the final read of index F. The stimulus first clears the read history with a soft reset. It then reads only part of the set, to show that the read of F leaves status byte 3 at zero, and then reads the rest and confirms 0x80 on the following read of F. Same-cycle conflicts are driven on purpose: read plus write at the acknowledge index, and an index load together with a data write. A long random phase then mixes all strobes and events, with a model compared on every clock.

// File: rtl/cdc_reg_pkg.sv
package cdc_reg_pkg;
    localparam int IDX_W   = 4;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int NUM_IDX = 1 << IDX_W;
    localparam int QUAD_W  = 4 * BYTE_W;
    localparam int CTRL_W  = 3 * BYTE_W;

    // write-side index roles
    localparam logic [IDX_W-1:0] W_SBOUT  = 4'h0;
    localparam logic [IDX_W-1:0] W_IFCTRL = 4'h1;
    localparam logic [IDX_W-1:0] W_CNT_LO = 4'h2;
    localparam logic [IDX_W-1:0] W_CNT_HI = 4'h3;
    localparam logic [IDX_W-1:0] W_DAC_LO = 4'h4;
    localparam logic [IDX_W-1:0] W_DAC_HI = 4'h5;
    localparam logic [IDX_W-1:0] W_TRIG   = 4'h6;
    localparam logic [IDX_W-1:0] W_ACK    = 4'h7;
    localparam logic [IDX_W-1:0] W_WA_LO  = 4'h8;
    localparam logic [IDX_W-1:0] W_WA_HI  = 4'h9;
    localparam logic [IDX_W-1:0] W_CTRL0  = 4'hA;
    localparam logic [IDX_W-1:0] W_CTRL1  = 4'hB;
    localparam logic [IDX_W-1:0] W_PT_LO  = 4'hC;
    localparam logic [IDX_W-1:0] W_PT_HI  = 4'hD;
    localparam logic [IDX_W-1:0] W_CTRL2  = 4'hE;
    localparam logic [IDX_W-1:0] W_SRST   = 4'hF;

    // reads that count toward decode completion
    localparam logic [NUM_IDX-1:0] DEC_READ_SET = 16'h73F2;

    typedef struct packed {
        logic [IDX_W-1:0]   idx;
        logic [BYTE_W-1:0]  ifstat;
        logic [BYTE_W-1:0]  ifctrl;
        logic [BYTE_W-1:0]  sbout;
        logic [WORD_W-1:0]  cnt;
        logic [WORD_W-1:0]  dac;
        logic [WORD_W-1:0]  pt;
        logic [WORD_W-1:0]  wa;
        logic [QUAD_W-1:0]  hdr;
        logic [QUAD_W-1:0]  stat;
        logic [CTRL_W-1:0]  ctrl;
        logic [NUM_IDX-1:0] rd_mask;
        logic               busy;
        logic               start;
        logic               srst;
    } cdc_state_t;
endpackage

// File: rtl/cdc_idx_step.sv
module cdc_idx_step import cdc_reg_pkg::*; #(
    parameter int IW = IDX_W
) (
    input  logic [IW-1:0] idx_q,
    input  logic          wr_act,
    input  logic          rd_act,
    input  logic          idx_we,
    input  logic [IW-1:0] idx_wdata,
    output logic [IW-1:0] idx_d
);
    localparam logic [IW-1:0] LAST_IDX = {IW{1'b1}};

    logic hold;

    always_comb begin
        if (wr_act)
            hold = (idx_q == W_TRIG) || (idx_q == W_ACK) ||
                   (idx_q == LAST_IDX - 1'b1) || (idx_q == LAST_IDX);
        else
            hold = (idx_q == LAST_IDX);

        idx_d = idx_q;
        if ((wr_act || rd_act) && !hold)
            idx_d = idx_q + 1'b1;
        if (idx_we)
            idx_d = idx_wdata;
    end
endmodule

// File: rtl/cdc_rd_mux.sv
module cdc_rd_mux import cdc_reg_pkg::*; (
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  cdc_state_t        st,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] view [NUM_IDX];

    always_comb begin
        view[0]  = cmd_byte;
        view[1]  = st.ifstat;
        view[2]  = st.cnt[BYTE_W-1:0];
        view[3]  = st.cnt[WORD_W-1:BYTE_W];
        view[8]  = st.pt[BYTE_W-1:0];
        view[9]  = st.pt[WORD_W-1:BYTE_W];
        view[10] = st.wa[BYTE_W-1:0];
        view[11] = st.wa[WORD_W-1:BYTE_W];
        for (int k = 0; k < 4; k++) begin
            view[4 + k]  = st.hdr[BYTE_W*k +: BYTE_W];
            view[12 + k] = st.stat[BYTE_W*k +: BYTE_W];
        end
        rd_data = view[idx];
    end
endmodule

// File: rtl/cdc_regfile.sv
module cdc_regfile import cdc_reg_pkg::*; #(
    parameter logic [BYTE_W-1:0] IFSTAT_INIT = 8'hFF,
    parameter logic [QUAD_W-1:0] HDR_INIT    = 32'h0100_0000,
    parameter logic [WORD_W-1:0] WA_INIT     = 16'd4704,
    parameter logic [QUAD_W-1:0] STAT_INIT   = 32'h0000_0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic [IDX_W-1:0]  idx_wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] cmd_in,
    input  logic              hdr_load,
    input  logic [QUAD_W-1:0] hdr_in,
    input  logic              dte_evt,
    input  logic              dec_evt,
    output logic [IDX_W-1:0]  idx_o,
    output logic              busy_o,
    output logic              xfer_start_o,
    output logic              soft_rst_o,
    output logic [BYTE_W-1:0] ifstat_o,
    output logic [BYTE_W-1:0] ifctrl_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] sbout_o,
    output logic [WORD_W-1:0] byte_cnt_o,
    output logic [WORD_W-1:0] data_addr_o
);
    localparam int XFER_EN_BIT  = 1;
    localparam int BUSY_N_BIT   = 3;
    localparam int DEC_IRQ_BIT  = 5;
    localparam int DTE_IRQ_BIT  = 6;
    localparam int DEC_EN_BIT   = 5;
    localparam int CTRL0_DEC_EN = 7;
    localparam logic [BYTE_W-1:0] DEC_DONE_VAL = 8'h80;
    localparam logic [IDX_W-1:0]  LAST_IDX     = {IDX_W{1'b1}};

    cdc_state_t st_q, st_d;
    logic [IDX_W-1:0] idx_next;
    logic rd_act;

    function automatic cdc_state_t init_state(input logic [IDX_W-1:0] keep_idx);
        cdc_state_t s;
        s         = '0;
        s.idx     = keep_idx;
        s.ifstat  = IFSTAT_INIT;
        s.hdr     = HDR_INIT;
        s.wa      = WA_INIT;
        s.stat    = STAT_INIT;
        return s;
    endfunction

    // a read only counts when no write shares the cycle
    assign rd_act = rd_en && !wr_en;

    cdc_idx_step #(.IW(IDX_W)) u_idx_step (
        .idx_q    (st_q.idx),
        .wr_act   (wr_en),
        .rd_act   (rd_act),
        .idx_we   (idx_we),
        .idx_wdata(idx_wdata),
        .idx_d    (idx_next)
    );

    cdc_rd_mux u_rd_mux (
        .idx     (st_q.idx),
        .cmd_byte(cmd_in),
        .st      (st_q),
        .rd_data (rd_data)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.srst  = 1'b0;
        st_d.idx   = idx_next;

        if (wr_en) begin
            unique case (st_q.idx)
                W_SBOUT:  st_d.sbout = wr_data;
                W_IFCTRL: begin
                    st_d.ifctrl = wr_data;
                    if (!wr_data[XFER_EN_BIT]) begin
                        st_d.cnt                = '0;
                        st_d.busy               = 1'b0;
                        st_d.ifstat[BUSY_N_BIT] = 1'b1;
                    end
                end
                W_CNT_LO: st_d.cnt[BYTE_W-1:0]      = wr_data;
                W_CNT_HI: st_d.cnt[WORD_W-1:BYTE_W] = wr_data;
                W_DAC_LO: st_d.dac[BYTE_W-1:0]      = wr_data;
                W_DAC_HI: st_d.dac[WORD_W-1:BYTE_W] = wr_data;
                W_TRIG: begin
                    if (st_q.ifctrl[XFER_EN_BIT]) begin
                        st_d.ifstat[BUSY_N_BIT] = 1'b0;
                        st_d.busy               = 1'b1;
                        st_d.start              = 1'b1;
                    end
                end
                W_ACK:    st_d.ifstat[DTE_IRQ_BIT]        = 1'b1;
                W_WA_LO:  st_d.wa[BYTE_W-1:0]             = wr_data;
                W_WA_HI:  st_d.wa[WORD_W-1:BYTE_W]        = wr_data;
                W_CTRL0:  st_d.ctrl[BYTE_W-1:0]           = wr_data;
                W_CTRL1:  st_d.ctrl[2*BYTE_W-1:BYTE_W]    = wr_data;
                W_PT_LO:  st_d.pt[BYTE_W-1:0]             = wr_data;
                W_PT_HI:  st_d.pt[WORD_W-1:BYTE_W]        = wr_data;
                W_CTRL2:  st_d.ctrl[CTRL_W-1:2*BYTE_W]    = wr_data;
                W_SRST:   st_d.srst                       = 1'b1;
                default:  ;
            endcase
        end else if (rd_act) begin
            if (DEC_READ_SET[st_q.idx])
                st_d.rd_mask[st_q.idx] = 1'b1;
            if (st_q.idx == LAST_IDX) begin
                st_d.ifstat[DEC_IRQ_BIT] = 1'b1;
                if (st_q.ctrl[CTRL0_DEC_EN] && st_q.ifctrl[DEC_EN_BIT] &&
                    ((st_q.rd_mask & DEC_READ_SET) == DEC_READ_SET))
                    st_d.stat[QUAD_W-1 -: BYTE_W] = DEC_DONE_VAL;
            end
        end

        if (hdr_load)
            st_d.hdr = hdr_in;
        if (dte_evt)
            st_d.ifstat[DTE_IRQ_BIT] = 1'b0;
        if (dec_evt)
            st_d.ifstat[DEC_IRQ_BIT] = 1'b0;

        if (st_d.srst) begin
            st_d      = init_state(idx_next);
            st_d.srst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= init_state('0);
        else
            st_q <= st_d;
    end

    assign idx_o        = st_q.idx;
    assign busy_o       = st_q.busy;
    assign xfer_start_o = st_q.start;
    assign soft_rst_o   = st_q.srst;
    assign ifstat_o     = st_q.ifstat;
    assign ifctrl_o     = st_q.ifctrl;
    assign ctrl_o       = st_q.ctrl;
    assign sbout_o      = st_q.sbout;
    assign byte_cnt_o   = st_q.cnt;
    assign data_addr_o  = st_q.dac;

    // index must not move on the holding writes
    assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !idx_we && (idx_o == W_TRIG || idx_o == W_ACK ||
                              idx_o == W_CTRL2 || idx_o == W_SRST))
        |=> $stable(idx_o));

    assert_idx_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !idx_we && idx_o != LAST_IDX)
        |=> idx_o == $past(idx_o) + 1'b1);

    assert_idx_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> idx_o == $past(idx_wdata));

    assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_o == W_IFCTRL && !wr_data[XFER_EN_BIT])
        |=> (!busy_o && byte_cnt_o == '0 && ifstat_o[BUSY_N_BIT]));

    assert_trig_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_o == W_TRIG && ifctrl_o[XFER_EN_BIT])
        |=> (busy_o && xfer_start_o && !ifstat_o[BUSY_N_BIT]));

    assert_start_needs_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(wr_en && idx_o == W_TRIG));

    assert_ack_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_o == W_ACK && !dte_evt) |=> ifstat_o[DTE_IRQ_BIT]);

    assert_f_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && idx_o == LAST_IDX && !dec_evt) |=> ifstat_o[DEC_IRQ_BIT]);

    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_o == W_SRST)
        |=> (soft_rst_o && ifstat_o == IFSTAT_INIT && !busy_o && ctrl_o == '0));
endmodule

// File: tb/cdc_regfile_tb.sv
`timescale 1ns/1ps
module cdc_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        idx_we;
    logic [3:0]  idx_wdata;
    logic        rd_en, wr_en;
    logic [7:0]  wr_data, rd_data, cmd_in;
    logic        hdr_load;
    logic [31:0] hdr_in;
    logic        dte_evt, dec_evt;
    logic [3:0]  idx_o;
    logic        busy_o, xfer_start_o, soft_rst_o;
    logic [7:0]  ifstat_o, ifctrl_o, sbout_o;
    logic [23:0] ctrl_o;
    logic [15:0] byte_cnt_o, data_addr_o;

    always #2 clk = ~clk;

    cdc_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cmd_in(cmd_in), .hdr_load(hdr_load), .hdr_in(hdr_in),
        .dte_evt(dte_evt), .dec_evt(dec_evt), .idx_o(idx_o), .busy_o(busy_o),
        .xfer_start_o(xfer_start_o), .soft_rst_o(soft_rst_o),
        .ifstat_o(ifstat_o), .ifctrl_o(ifctrl_o), .ctrl_o(ctrl_o),
        .sbout_o(sbout_o), .byte_cnt_o(byte_cnt_o), .data_addr_o(data_addr_o)
    );

    int checks = 0;
    int failures = 0;
    string cur_req = "R9";
    logic [7:0] last_rd;

    // behavioural model state
    int m_idx, m_ifstat, m_ifctrl, m_sbout, m_cnt, m_dac, m_pt, m_wa;
    int m_busy, m_start, m_srst, m_mask;
    int m_hdr[4];
    int m_stat[4];
    int m_ctrl[3];

    task automatic m_defaults();
        m_ifstat = 'hFF; m_ifctrl = 0; m_sbout = 0; m_cnt = 0; m_dac = 0;
        m_pt = 0; m_wa = 4704; m_busy = 0; m_start = 0; m_mask = 0;
        m_hdr = '{0, 0, 0, 1};
        m_stat = '{'h80, 0, 0, 0};
        m_ctrl = '{0, 0, 0};
    endtask

    function automatic int m_rd();
        case (m_idx)
            0: return int'(cmd_in);
            1: return m_ifstat;
            2: return m_cnt & 255;
            3: return (m_cnt >> 8) & 255;
            4, 5, 6, 7: return m_hdr[m_idx - 4];
            8: return m_pt & 255;
            9: return (m_pt >> 8) & 255;
            10: return m_wa & 255;
            11: return (m_wa >> 8) & 255;
            default: return m_stat[m_idx - 12];
        endcase
    endfunction

    task automatic m_step();
        int o_idx, nidx, d;
        o_idx = m_idx; nidx = m_idx; d = int'(wr_data);
        m_start = 0; m_srst = 0;
        if (wr_en) begin
            case (o_idx)
                0: m_sbout = d;
                1: begin
                    m_ifctrl = d;
                    if (((d >> 1) & 1) == 0) begin m_cnt = 0; m_busy = 0; m_ifstat = m_ifstat | 8; end
                end
                2: m_cnt = (m_cnt & 'hFF00) | d;
                3: m_cnt = (m_cnt & 'h00FF) | (d << 8);
                4: m_dac = (m_dac & 'hFF00) | d;
                5: m_dac = (m_dac & 'h00FF) | (d << 8);
                6: if ((m_ifctrl >> 1) & 1) begin m_ifstat = m_ifstat & 'hF7; m_busy = 1; m_start = 1; end
                7: m_ifstat = m_ifstat | 'h40;
                8: m_wa = (m_wa & 'hFF00) | d;
                9: m_wa = (m_wa & 'h00FF) | (d << 8);
                10: m_ctrl[0] = d;
                11: m_ctrl[1] = d;
                12: m_pt = (m_pt & 'hFF00) | d;
                13: m_pt = (m_pt & 'h00FF) | (d << 8);
                14: m_ctrl[2] = d;
                default: m_srst = 1;
            endcase
            if (!(o_idx == 6 || o_idx == 7 || o_idx == 14 || o_idx == 15)) nidx = (o_idx + 1) % 16;
        end else if (rd_en) begin
            if (o_idx == 1 || (o_idx >= 4 && o_idx <= 9) || (o_idx >= 12 && o_idx <= 14))
                m_mask = m_mask | (1 << o_idx);
            if (o_idx == 15) begin
                m_ifstat = m_ifstat | 'h20;
                if (((m_ctrl[0] >> 7) & 1) && ((m_ifctrl >> 5) & 1) && ((m_mask & 'h73F2) == 'h73F2))
                    m_stat[3] = 'h80;
            end else nidx = (o_idx + 1) % 16;
        end
        if (idx_we) nidx = int'(idx_wdata);
        if (hdr_load) for (int k = 0; k < 4; k++) m_hdr[k] = int'(hdr_in[8*k +: 8]);
        if (dte_evt) m_ifstat = m_ifstat & 'hBF;
        if (dec_evt) m_ifstat = m_ifstat & 'hDF;
        if (m_srst) m_defaults();
        m_idx = nidx;
    endtask

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_state();
        logic [86:0] a, e;
        a = {idx_o, busy_o, xfer_start_o, soft_rst_o, ifstat_o, ifctrl_o, ctrl_o,
             sbout_o, byte_cnt_o, data_addr_o};
        e = {m_idx[3:0], m_busy[0], m_start[0], m_srst[0], m_ifstat[7:0], m_ifctrl[7:0],
             m_ctrl[2][7:0], m_ctrl[1][7:0], m_ctrl[0][7:0], m_sbout[7:0],
             m_cnt[15:0], m_dac[15:0]};
        chk({cur_req, " state"}, {41'd0, a}, {41'd0, e});
    endtask

    task automatic op(input bit we, input bit re, input logic [7:0] d,
                      input bit iwe = 0, input logic [3:0] iw = 0,
                      input bit hl = 0, input logic [31:0] hv = 0,
                      input bit de = 0, input bit dc = 0);
        int er;
        wr_en = we; rd_en = re; wr_data = d; idx_we = iwe; idx_wdata = iw;
        hdr_load = hl; hdr_in = hv; dte_evt = de; dec_evt = dc;
        #1;
        er = m_rd();
        last_rd = rd_data;
        chk({cur_req, " rd_data"}, {120'd0, rd_data}, {120'd0, er[7:0]});
        @(posedge clk);
        m_step();
        @(negedge clk);
        chk_state();
        wr_en = 0; rd_en = 0; idx_we = 0; hdr_load = 0; dte_evt = 0; dec_evt = 0;
    endtask

    task automatic seti(input logic [3:0] i);
        op(0, 0, 8'h00, 1, i);
    endtask

    task automatic wr(input logic [7:0] d);
        op(1, 0, d);
    endtask

    task automatic rd();
        op(0, 1, 8'h00);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog all-requirements act=running exp=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; idx_we = 0; idx_wdata = 0; rd_en = 0; wr_en = 0; wr_data = 0;
        cmd_in = 8'h5A; hdr_load = 0; hdr_in = 0; dte_evt = 0; dec_evt = 0;
        m_idx = 0; m_srst = 0; m_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R9 reset state
        cur_req = "R9";
        op(0, 0, 8'h00);

        // R1 full read sweep, R3 advance and hold at F
        cur_req = "R1";
        for (int k = 0; k < 16; k++) begin
            rd();
            if (k == 0)  chk("R1 cmd byte", {120'd0, last_rd}, {120'd0, 8'h5A});
            if (k == 7)  chk("R9 header byte3", {120'd0, last_rd}, {120'd0, 8'h01});
            if (k == 10) chk("R9 wa low", {120'd0, last_rd}, {120'd0, 8'h60});
            if (k == 11) chk("R9 wa high", {120'd0, last_rd}, {120'd0, 8'h12});
            if (k == 12) chk("R9 status0", {120'd0, last_rd}, {120'd0, 8'h80});
        end
        chk("R3 read F holds", {124'd0, idx_o}, {124'd0, 4'hF});

        // R2 / R4 counters
        cur_req = "R2";
        seti(4'h2);
        wr(8'h34); wr(8'h12); wr(8'h78); wr(8'h56);
        chk("R2 byte count", {112'd0, byte_cnt_o}, {112'd0, 16'h1234});
        chk("R2 data addr", {112'd0, data_addr_o}, {112'd0, 16'h5678});
        chk("R3 write advance", {124'd0, idx_o}, {124'd0, 4'h6});

        // R6 trigger gated by enable
        cur_req = "R6";
        wr(8'h00);
        chk("R6 no start when disabled", {127'd0, busy_o}, {127'd0, 1'b0});
        seti(4'h1); wr(8'h22);
        seti(4'h6); wr(8'h00);
        chk("R6 busy set", {127'd0, busy_o}, {127'd0, 1'b1});
        chk("R3 trig holds idx", {124'd0, idx_o}, {124'd0, 4'h6});

        // R7 event then acknowledge
        cur_req = "R7";
        op(0, 0, 8'h00, 0, 0, 0, 0, 1, 0);
        chk("R7 dte flag low", {127'd0, ifstat_o[6]}, {127'd0, 1'b0});
        seti(4'h7); wr(8'h00);
        chk("R7 ack sets bit6", {127'd0, ifstat_o[6]}, {127'd0, 1'b1});

        // R5 stop
        cur_req = "R5";
        seti(4'h1); wr(8'h20);
        chk("R5 count cleared", {112'd0, byte_cnt_o}, {112'd0, 16'h0000});
        chk("R5 busy_n set", {127'd0, ifstat_o[3]}, {127'd0, 1'b1});

        // R2 upper write map
        cur_req = "R2";
        seti(4'h8);
        wr(8'h11); wr(8'h22); wr(8'h80); wr(8'h33); wr(8'h44); wr(8'h55); wr(8'h66);
        chk("R2 control bytes", {104'd0, ctrl_o}, {104'd0, 24'h663380});
        chk("R3 ctrl2 holds", {124'd0, idx_o}, {124'd0, 4'hE});
        seti(4'h8);
        rd(); chk("R1 pointer low", {120'd0, last_rd}, {120'd0, 8'h44});
        rd(); chk("R1 pointer high", {120'd0, last_rd}, {120'd0, 8'h55});
        rd(); chk("R1 wa low", {120'd0, last_rd}, {120'd0, 8'h11});

        // R9 soft reset
        cur_req = "R9";
        seti(4'hF); wr(8'h00);
        chk("R9 soft pulse", {127'd0, soft_rst_o}, {127'd0, 1'b1});
        chk("R9 ifstat reset", {120'd0, ifstat_o}, {120'd0, 8'hFF});

        // R8 decode completion
        cur_req = "R8";
        seti(4'h1); wr(8'h20);
        seti(4'hA); wr(8'h80);
        op(0, 0, 8'h00, 0, 0, 0, 0, 0, 1);
        chk("R8 dec flag low", {127'd0, ifstat_o[5]}, {127'd0, 1'b0});
        seti(4'h1); rd();
        seti(4'h4); for (int k = 0; k < 6; k++) rd();
        seti(4'hF); rd();
        chk("R8 F read sets bit5", {127'd0, ifstat_o[5]}, {127'd0, 1'b1});
        rd(); chk("R8 incomplete stays 0", {120'd0, last_rd}, {120'd0, 8'h00});
        seti(4'hC); rd(); rd(); rd();
        rd(); rd();
        chk("R8 status3 done", {120'd0, last_rd}, {120'd0, 8'h80});

        // R10 read and write together at ack index
        cur_req = "R10";
        seti(4'h7);
        op(0, 0, 8'h00, 0, 0, 0, 0, 1, 0);
        op(1, 1, 8'h00);
        chk("R10 idx held", {124'd0, idx_o}, {124'd0, 4'h7});
        chk("R10 ack done", {127'd0, ifstat_o[6]}, {127'd0, 1'b1});

        // R4 index load with data write
        cur_req = "R4";
        seti(4'h0);
        op(1, 0, 8'h99, 1, 4'h9);
        chk("R4 sbout", {120'd0, sbout_o}, {120'd0, 8'h99});
        chk("R4 idx loaded", {124'd0, idx_o}, {124'd0, 4'h9});

        // R11 header load and reset priority
        cur_req = "R11";
        op(0, 0, 8'h00, 1, 4'h4, 1, 32'hA1B2_C3D4);
        rd(); chk("R11 header0", {120'd0, last_rd}, {120'd0, 8'hD4});
        seti(4'hF);
        op(1, 0, 8'h00, 0, 0, 1, 32'hFFFF_0000);
        seti(4'h7); rd();
        chk("R11 reset wins", {120'd0, last_rd}, {120'd0, 8'h01});

        // random mix
        cur_req = "random R1 R2 R3 R7";
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            cmd_in = 8'($urandom);
            op(r < 45, (r >= 30) && (r < 80), 8'($urandom),
               ($urandom_range(0, 9) == 0), 4'($urandom),
               ($urandom_range(0, 19) == 0), $urandom,
               ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
        end

        finish_run();
    end
endmodule